// File: doc/BRIEF.md
# Byte-Swappable Parallel Result Port

This block is the parallel read side of a 16-bit converter's digital back end. It keeps the latest conversion result in a register and presents it on a 16-bit data bus, modelled as a data vector plus a per-bit output enable, while the host holds chip select and read strobe low. Outside that window, or whenever the mode input selects serial operation, every bus bit is released.

A swap input exchanges the two byte lanes. An 8-bit host wires swap to an address line and fetches the word in two reads from the same eight pins. The result register only changes on the converter core's result-ready strobe. A host that reads while a conversion is running therefore gets the previous result, so reads can overlap conversions. A BUSY flag covers the span from the conversion-start pulse to the latching of the new result.

Top module: `byte_swap_result_port`

## Requirements
- R1: While `ser_mode` is 1 at a rising edge, `bus_oe` is all zero and `bus_out` is zero after that edge.
- R2: The bus is enabled after a rising edge only if `ser_mode`, `cs_n` and `rd_n` were all 0 at that edge. Otherwise `bus_oe` is all zero and `bus_out` is zero. When enabled, all 16 `bus_oe` bits are 1.
- R3: With `swap` 0 at the edge, `bus_out[7:0]` is the result's bits 7:0 and `bus_out[15:8]` is the result's bits 15:8.
- R4: With `swap` 1 at the edge, `bus_out[15:8]` is the result's bits 7:0 and `bus_out[7:0]` is the result's bits 15:8.
- R5: The result register loads `core_data` at an edge where `result_ready` is 1, and holds its value otherwise. The bus shows the register's value from before each edge, so a new result appears on the bus one clock after it is latched. Reads during a conversion return the prior result.
- R6: `busy` is 1 after any edge at which `conv_start` was 1.
- R7: `busy` is 0 after an edge at which `result_ready` was 1 and `conv_start` was 0. Otherwise `busy` keeps its value.
- R8: Toggling `swap` during a continuous read changes the lane mapping on the next clock, with no other input change.
- R9: After a synchronous reset, the result register is zero, `busy` is 0 and the bus is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_mode | input | 1 | 1 selects serial mode (parallel port released), 0 selects parallel |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| swap | input | 1 | Byte-lane exchange select |
| conv_start | input | 1 | Conversion-start pulse |
| result_ready | input | 1 | Converter core strobe: `core_data` holds a new result |
| core_data | input | 16 | Result word from the converter core |
| bus_out | output | 16 | Data bus value |
| bus_oe | output | 16 | Per-bit output enable of the data bus |
| busy | output | 1 | Conversion in progress |

## Verification
A result register that loads at the wrong time shows as a changed word on the very next enabled read, one clock later. A busy flag that is set or cleared wrongly differs at `busy` on the clock right after the start or ready strobe. A wrong lane mapping or enable decode shows at the bus one clock after the offending input combination. The bench sweeps every combination of mode, select, strobe and swap over several data patterns, so each of these faults appears within a cycle of the stimulus that reaches it.

// File: rtl/rp_pkg.sv
package rp_pkg;
    localparam int DATA_W  = 16;
    localparam int LANE_W  = 8;
    localparam int N_LANES = DATA_W / LANE_W;

    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        logic ser_mode;
        logic cs_n;
        logic rd_n;
        logic swap;
    } host_ctl_t;

    typedef struct packed {
        logic  drive;
        word_t data;
    } bus_t;

    function automatic logic port_enabled(host_ctl_t c);
        return !c.ser_mode && !c.cs_n && !c.rd_n;
    endfunction
endpackage

// File: rtl/rp_result_store.sv
module rp_result_store
    import rp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  word_t din,
    output word_t q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= din;
    end

    p_load_r5: assert property (@(posedge clk) disable iff (rst)
        load |=> q == $past(din));
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));
endmodule

// File: rtl/rp_busy_track.sv
module rp_busy_track (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic done,
    output logic busy
);
    always_ff @(posedge clk) begin
        if (rst)        busy <= 1'b0;
        else if (start) busy <= 1'b1;
        else if (done)  busy <= 1'b0;
    end

    p_busy_rise_r6: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);
    p_busy_fall_r7: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> !busy);
endmodule

// File: rtl/rp_lane_steer.sv
module rp_lane_steer
    import rp_pkg::*;
(
    input  word_t word_in,
    input  logic  swap,
    output word_t word_out
);
    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        localparam int MIRROR = N_LANES - 1 - i;
        assign word_out[i*LANE_W +: LANE_W] = swap ? word_in[MIRROR*LANE_W +: LANE_W]
                                                   : word_in[i*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/byte_swap_result_port.sv
module byte_swap_result_port
    import rp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_mode,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              swap,
    input  logic              conv_start,
    input  logic              result_ready,
    input  logic [DATA_W-1:0] core_data,
    output logic [DATA_W-1:0] bus_out,
    output logic [DATA_W-1:0] bus_oe,
    output logic              busy
);
    host_ctl_t ctl;
    word_t     result_q;
    word_t     steered;
    bus_t      bus_q;

    assign ctl = '{ser_mode: ser_mode, cs_n: cs_n, rd_n: rd_n, swap: swap};

    rp_result_store u_store (
        .clk (clk), .rst (rst), .load (result_ready), .din (core_data), .q (result_q)
    );

    rp_busy_track u_busy (
        .clk (clk), .rst (rst), .start (conv_start), .done (result_ready), .busy (busy)
    );

    rp_lane_steer u_steer (
        .word_in (result_q), .swap (ctl.swap), .word_out (steered)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_q <= '0;
        end else if (port_enabled(ctl)) begin
            bus_q.drive <= 1'b1;
            bus_q.data  <= steered;
        end else begin
            bus_q <= '0;
        end
    end

    assign bus_out = bus_q.data;
    assign bus_oe  = {DATA_W{bus_q.drive}};

    p_serial_release_r1: assert property (@(posedge clk) disable iff (rst)
        ser_mode |=> bus_oe == '0);
    p_deselect_release_r2: assert property (@(posedge clk) disable iff (rst)
        (cs_n || rd_n) |=> (bus_oe == '0 && bus_out == '0));
    p_straight_lanes_r3: assert property (@(posedge clk) disable iff (rst)
        (!ser_mode && !cs_n && !rd_n && !swap) |=> bus_out == $past(result_q));
    p_swapped_lanes_r4: assert property (@(posedge clk) disable iff (rst)
        (!ser_mode && !cs_n && !rd_n && swap) |=>
        bus_out == {$past(result_q[LANE_W-1:0]), $past(result_q[DATA_W-1:LANE_W])});
    p_oe_uniform_r2: assert property (@(posedge clk) disable iff (rst)
        $countones(bus_oe) == 0 || $countones(bus_oe) == DATA_W);
endmodule

// File: tb/sim_byte_swap_result_port.sv
module sim_byte_swap_result_port;
    logic        clk = 1'b0;
    logic        rst;
    logic        ser_mode, cs_n, rd_n, swap, conv_start, result_ready;
    logic [15:0] core_data;
    logic [15:0] bus_out, bus_oe;
    logic        busy;

    int errors = 0;
    int checks = 0;

    logic [15:0] m_res;
    logic        m_busy;

    always #2.5 clk = ~clk;

    byte_swap_result_port u0 (
        .clk (clk), .rst (rst), .ser_mode (ser_mode), .cs_n (cs_n), .rd_n (rd_n),
        .swap (swap), .conv_start (conv_start), .result_ready (result_ready),
        .core_data (core_data), .bus_out (bus_out), .bus_oe (bus_oe), .busy (busy)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock: model the spec from the inputs held across the edge, then compare.
    task automatic step(input string tag);
        logic        en;
        logic [15:0] exp_bus;
        string       t;
        en      = !ser_mode && !cs_n && !rd_n;
        exp_bus = !en ? 16'h0 : (swap ? {m_res[7:0], m_res[15:8]} : m_res);
        if (result_ready) m_res = core_data;
        if (conv_start)        m_busy = 1'b1;
        else if (result_ready) m_busy = 1'b0;
        @(posedge clk);
        #1;
        t = (tag != "") ? tag : (!en ? (ser_mode ? "R1" : "R2") : (swap ? "R4" : "R3"));
        check(t, {16'h0, bus_out}, {16'h0, exp_bus});
        check(en ? "R2" : t, {16'h0, bus_oe}, en ? 32'h0000_FFFF : 32'h0);
        check(conv_start ? "R6" : "R7", {31'h0, busy}, {31'h0, m_busy});
    endtask

    task automatic load_word(input logic [15:0] w);
        core_data    = w;
        result_ready = 1'b1;
        step("R5");
        result_ready = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] pats [4];
        pats[0] = 16'h12A5; pats[1] = 16'hFF00; pats[2] = 16'h00FF; pats[3] = 16'hC33C;

        rst = 1'b1; ser_mode = 1'b0; cs_n = 1'b0; rd_n = 1'b0; swap = 1'b0;
        conv_start = 1'b0; result_ready = 1'b0; core_data = 16'hFFFF;
        m_res = 16'h0; m_busy = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        check("R9", {16'h0, bus_oe}, 32'h0);
        check("R9", {31'h0, busy}, 32'h0);
        rst = 1'b0;
        step("R9");   // reads zero result right after reset

        // Exhaustive sweep of control inputs over several data words (R1-style tags chosen per case)
        for (int p = 0; p < 4; p++) begin
            load_word(pats[p]);
            for (int c = 0; c < 16; c++) begin
                {ser_mode, cs_n, rd_n, swap} = c[3:0];
                step("");
            end
        end

        // R5 / R6 / R7: read during conversion returns prior result
        ser_mode = 1'b0; cs_n = 1'b0; rd_n = 1'b0; swap = 1'b0;
        load_word(16'hBEEF);
        conv_start = 1'b1; step("R6"); conv_start = 1'b0;
        core_data = 16'h1234;
        step("R5"); step("R5");
        result_ready = 1'b1; step("R7"); result_ready = 1'b0;
        step("R5");   // new word visible now
        check("R5", {16'h0, bus_out}, 32'h1234);

        // R7: simultaneous start and ready keeps busy high
        conv_start = 1'b1; result_ready = 1'b1; core_data = 16'h5A5A;
        step("R7");
        conv_start = 1'b0; result_ready = 1'b0;
        step("R7");
        result_ready = 1'b1; core_data = 16'h0F0F; step("R7"); result_ready = 1'b0;

        // R8: swap toggled within one continuous read
        for (int k = 0; k < 6; k++) begin
            swap = k[0];
            step("R8");
        end

        // R9: reset mid-operation
        conv_start = 1'b1; step("R6"); conv_start = 1'b0;
        rst = 1'b1; @(posedge clk); #1; rst = 1'b0;
        m_res = 16'h0; m_busy = 1'b0;
        check("R9", {31'h0, busy}, 32'h0);
        swap = 1'b0;
        step("R9");
        check("R9", {16'h0, bus_out}, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule